// File: doc/BRIEF.md
# Packet Device Task-File Controller

This block is the device-side register set and transfer sequencer of a disc drive that takes commands as packets over a parallel ATA link. The host writes the command, control and feature registers and a 16-bit data port. The block keeps the status, error, interrupt-reason and byte-count registers, and it tracks a pending interrupt behind a host mask bit. When the packet opcode is written, the block collects a 12-byte command packet from six data-port writes and presents it to an external packet decoder as a one-cycle strobe.

The decoder fills a local word buffer and answers with a done/error handshake that carries a transfer length. A non-zero length starts a PIO read, which the host drains word by word through the data port, or a DMA read, which ends with an external completion strobe. Every phase loads fixed codes into status and interrupt reason, so host firmware can follow the sequence by polling status alone.

Top module: `pkt_taskfile_ctrl`

## Requirements
- R1: After a synchronous reset the outputs read status 0x00, error 0x01, interrupt reason 0x01, sector 0x81, byte count low 0x14 and high 0xEB, reset-seen flag 1, irq 0 and data port 0xFFFF.
- R2: Writing opcode 0xA0 to the command register gives status 0x58, interrupt reason 0x01 (bit0 = command/data, bit1 = I/O), and an error register equal to the feature register's bits [1:0].
- R3: In packet collection each data-port write stores one word, with the low byte as the even packet byte. After the sixth word the next cycle shows status 0xD0, a one-cycle packet strobe with packet byte i at bits [8i+7:8i], and the reset-seen flag at 0. Data-port writes in other states change nothing.
- R4: A decoder done with the error flag gives status 0x51, error = code<<4, interrupt reason 0x03 and an interrupt. A done with no error and length 0 gives status 0x50, error 0x00, interrupt reason 0x03 and an interrupt.
- R5: A done with length L>0 while feature bit0 is 0 starts a PIO read: status 0x58, error 0x00, interrupt reason 0x02, byte count low/high = L[7:0]/L[15:8], and an interrupt.
- R6: Each data-port read during a PIO read returns the buffer word at the current byte offset/2 one cycle later and advances the offset by 2. Once the offset reaches L, status becomes 0x50, interrupt reason 0x03 and an interrupt is raised. A read in any other state returns 0xFFFF.
- R7: A done with length L>0 while feature bit0 is 1 gives status 0xD0 and interrupt reason 0x02, raises no interrupt and leaves the byte count unchanged. The DMA completion strobe then gives status 0x50, interrupt reason 0x03 and an interrupt.
- R8: Opcode 0x00 aborts. The block goes idle with status 0x51 and error 0x04 and raises an interrupt.
- R9: Opcode 0xEF gives status 0x50, error 0x00, byte count low and high 0x00, and an interrupt.
- R10: irq equals the pending flag AND NOT control bit1. A control write re-evaluates irq against the pending flag in the next cycle.
- R11: Any command write first clears the pending flag, so an unrecognised opcode only drops irq. A status-read strobe clears the pending flag only while status bit7 (busy) is 0.
- R12: Opcode 0x08 restores every R1 value except the control register, clears the pending flag and sets the reset-seen flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cmd_we | input | 1 | Command register write strobe |
| host_cmd | input | 8 | Command opcode |
| host_ctl_we | input | 1 | Control register write strobe |
| host_ctl | input | 8 | Control value, bit1 masks irq |
| host_feat_we | input | 1 | Feature register write strobe |
| host_feat | input | 8 | Feature value, bit0 DMA, bit1 overlap |
| host_data_we | input | 1 | Data port write strobe |
| host_wdata | input | 16 | Data port write word |
| host_data_re | input | 1 | Data port read strobe |
| host_rdata | output | 16 | Data port read word, valid one cycle after the strobe |
| host_stat_re | input | 1 | Status read strobe (acknowledge) |
| status_o | output | 8 | Status register |
| error_o | output | 8 | Error register |
| ireason_o | output | 8 | Interrupt reason register |
| sect_o | output | 8 | Sector number register |
| bcnt_lo_o | output | 8 | Byte count low |
| bcnt_hi_o | output | 8 | Byte count high |
| rst_seen_o | output | 1 | Set by reset, cleared at packet dispatch |
| irq_o | output | 1 | Interrupt line to host |
| pkt_valid_o | output | 1 | One-cycle packet dispatch strobe |
| pkt_bytes_o | output | 96 | Collected command packet |
| pkt_done_i | input | 1 | Decoder finished the packet |
| pkt_err_i | input | 1 | Decoder reports failure |
| pkt_code_i | input | 4 | Failure code |
| pkt_len_i | input | 12 | Bytes to return to host |
| fill_we_i | input | 1 | Buffer fill write strobe |
| fill_addr_i | input | 11 | Buffer word address |
| fill_data_i | input | 16 | Buffer fill word |
| dma_done_i | input | 1 | DMA engine finished the read |

## Verification
A wrong internal state shows at the ports within one clock: the phase codes go to status and interrupt reason on the edge after the strobe that causes them, so a missed transition or a wrong branch appears as a wrong status byte at the next sample. A wrong transfer offset shows as a wrong read word, or as a completion one word early or late. A wrong pending flag shows on irq only after the host mask is cleared, so the bench toggles the mask while an interrupt is pending and compares a cycle-accurate model on every clock.

// File: rtl/tf_pkg.sv
// Shared encodings of the task-file controller: sequencer states, host
// opcodes, and the fixed codes loaded into status and interrupt reason.
package tf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD_WR, ST_BUSY, ST_PIO_RD, ST_DMA_RD
    } tf_state_e;

    localparam logic [7:0] OP_NOP      = 8'h00;
    localparam logic [7:0] OP_DEV_RST  = 8'h08;
    localparam logic [7:0] OP_PACKET   = 8'hA0;
    localparam logic [7:0] OP_SET_FEAT = 8'hEF;

    localparam int BIT_BSY = 7;
    localparam int BIT_DRQ = 3;

    localparam logic [7:0] STAT_XFER = 8'h58;
    localparam logic [7:0] STAT_BUSY = 8'hD0;
    localparam logic [7:0] STAT_DONE = 8'h50;
    localparam logic [7:0] STAT_FAIL = 8'h51;

    localparam logic [7:0] IR_CMD  = 8'h01;
    localparam logic [7:0] IR_IO   = 8'h02;
    localparam logic [7:0] IR_DONE = 8'h03;
endpackage

// File: rtl/tf_irq_ctrl.sv
// Interrupt tracker: holds the pending flag and gates it with the host mask.
// Assumes raise and clear are single-cycle strobes; raise wins a tie.
module tf_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clear,
    input  logic mask,
    output logic pending_o,
    output logic irq_o
);
    // Pending flag: set on raise, dropped on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     pending_o <= 1'b0;
        else if (raise) pending_o <= 1'b1;
        else if (clear) pending_o <= 1'b0;
    end

    // External line follows pending unless masked.
    assign irq_o = pending_o & ~mask;
endmodule

// File: rtl/tf_word_buf.sv
// Sector word buffer: one write port for the decoder side, one
// synchronous read port for the host data port. No reset on contents.
module tf_word_buf #(
    parameter int WORDS = 1176,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [15:0]   wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data
);
    logic [15:0] mem [WORDS];

    // Write and registered read.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/pkt_taskfile_ctrl.sv
// Device-side task-file controller for a packet-command drive. Collects a
// command packet over the 16-bit data port, hands it to a decoder, then
// runs a PIO or DMA read. Assumes host strobes are single-cycle and one
// register access per cycle; a feature write takes effect the next cycle.
module pkt_taskfile_ctrl
    import tf_pkg::*;
#(
    parameter int BUF_BYTES = 2352,
    parameter int PKT_BYTES = 12,
    parameter int LEN_W     = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_cmd_we,
    input  logic [7:0]             host_cmd,
    input  logic                   host_ctl_we,
    input  logic [7:0]             host_ctl,
    input  logic                   host_feat_we,
    input  logic [7:0]             host_feat,
    input  logic                   host_data_we,
    input  logic [15:0]            host_wdata,
    input  logic                   host_data_re,
    output logic [15:0]            host_rdata,
    input  logic                   host_stat_re,
    output logic [7:0]             status_o,
    output logic [7:0]             error_o,
    output logic [7:0]             ireason_o,
    output logic [7:0]             sect_o,
    output logic [7:0]             bcnt_lo_o,
    output logic [7:0]             bcnt_hi_o,
    output logic                   rst_seen_o,
    output logic                   irq_o,
    output logic                   pkt_valid_o,
    output logic [8*PKT_BYTES-1:0] pkt_bytes_o,
    input  logic                   pkt_done_i,
    input  logic                   pkt_err_i,
    input  logic [3:0]             pkt_code_i,
    input  logic [LEN_W-1:0]       pkt_len_i,
    input  logic                   fill_we_i,
    input  logic [$clog2(BUF_BYTES/2)-1:0] fill_addr_i,
    input  logic [15:0]            fill_data_i,
    input  logic                   dma_done_i
);
    localparam int BUF_WORDS = BUF_BYTES / 2;
    localparam int BAW       = $clog2(BUF_WORDS);
    localparam int PKT_WORDS = PKT_BYTES / 2;
    localparam int PIW       = $clog2(PKT_WORDS);

    tf_state_e        state_q, state_d;
    logic [7:0]       status_d, error_d, irsn_d, sect_d, blo_d, bhi_d, feat_q, feat_d, ctl_q;
    logic [LEN_W-1:0] ofs_q, ofs_d, len_q, len_d;
    logic             rs_d, pv_d, irq_raise, irq_clear, pending, rd_ffff_q, pio_act;
    logic [15:0]      len16, buf_rdata;
    logic [15:0]      pkt_w [PKT_WORDS];

    assign pio_act = (state_q == ST_PIO_RD);
    assign len16   = 16'(pkt_len_i);

    // Next-state and register-code selection for every host or decoder event.
    always_comb begin
        state_d = state_q;   status_d = status_o;  error_d = error_o;
        irsn_d  = ireason_o; sect_d   = sect_o;    blo_d   = bcnt_lo_o;
        bhi_d   = bcnt_hi_o; ofs_d    = ofs_q;     len_d   = len_q;
        rs_d    = rst_seen_o; pv_d    = 1'b0;      irq_raise = 1'b0;
        feat_d  = host_feat_we ? host_feat : feat_q;
        if (host_cmd_we) begin
            case (host_cmd)
                OP_NOP: begin
                    state_d = ST_IDLE; status_d = STAT_FAIL; error_d = 8'h04;
                    ofs_d = '0; irq_raise = 1'b1;
                end
                OP_DEV_RST: begin
                    state_d = ST_IDLE; status_d = 8'h00; error_d = 8'h01; irsn_d = 8'h01;
                    sect_d = 8'h81; blo_d = 8'h14; bhi_d = 8'hEB; feat_d = 8'h00;
                    ofs_d = '0; len_d = '0; rs_d = 1'b1;
                end
                OP_PACKET: begin
                    state_d = ST_CMD_WR; status_d = STAT_XFER; error_d = {6'b0, feat_q[1:0]};
                    irsn_d = IR_CMD; ofs_d = '0; len_d = LEN_W'(PKT_BYTES);
                end
                OP_SET_FEAT: begin
                    status_d = STAT_DONE; error_d = 8'h00; blo_d = 8'h00; bhi_d = 8'h00;
                    irq_raise = 1'b1;
                end
                default: ;
            endcase
        end else if (host_data_we && state_q == ST_CMD_WR) begin
            ofs_d = ofs_q + LEN_W'(2);
            if (ofs_d >= len_q) begin
                state_d = ST_BUSY; ofs_d = '0; pv_d = 1'b1; rs_d = 1'b0;
                status_d = status_o | 8'h80;
                status_d[BIT_DRQ] = 1'b0;
            end
        end else if (host_data_re && pio_act) begin
            ofs_d = ofs_q + LEN_W'(2);
            if (ofs_d >= len_q) begin
                state_d = ST_IDLE; ofs_d = '0; irsn_d = IR_DONE; irq_raise = 1'b1;
                status_d[BIT_DRQ] = 1'b0;
            end
        end else if (state_q == ST_BUSY && pkt_done_i) begin
            if (pkt_err_i) begin
                state_d = ST_IDLE; status_d = STAT_FAIL; error_d = {pkt_code_i, 4'b0};
                irsn_d = IR_DONE; irq_raise = 1'b1;
            end else if (pkt_len_i == '0) begin
                state_d = ST_IDLE; status_d = STAT_DONE; error_d = 8'h00;
                irsn_d = IR_DONE; irq_raise = 1'b1;
            end else begin
                error_d = 8'h00; irsn_d = IR_IO; ofs_d = '0; len_d = pkt_len_i;
                if (feat_q[0]) begin
                    state_d = ST_DMA_RD; status_d = STAT_BUSY;
                end else begin
                    state_d = ST_PIO_RD; status_d = STAT_XFER;
                    blo_d = len16[7:0]; bhi_d = len16[15:8]; irq_raise = 1'b1;
                end
            end
        end else if (state_q == ST_DMA_RD && dma_done_i) begin
            state_d = ST_IDLE; status_d = STAT_DONE; irsn_d = IR_DONE; irq_raise = 1'b1;
        end
    end

    assign irq_clear = host_cmd_we | (host_stat_re & ~status_o[BIT_BSY]);

    // Task-file registers and sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; status_o <= 8'h00; error_o <= 8'h01; ireason_o <= 8'h01;
            sect_o <= 8'h81; bcnt_lo_o <= 8'h14; bcnt_hi_o <= 8'hEB; feat_q <= 8'h00;
            ctl_q <= 8'h00; ofs_q <= '0; len_q <= '0; rst_seen_o <= 1'b1; pkt_valid_o <= 1'b0;
        end else begin
            state_q <= state_d; status_o <= status_d; error_o <= error_d; ireason_o <= irsn_d;
            sect_o <= sect_d; bcnt_lo_o <= blo_d; bcnt_hi_o <= bhi_d; feat_q <= feat_d;
            ofs_q <= ofs_d; len_q <= len_d; rst_seen_o <= rs_d; pkt_valid_o <= pv_d;
            if (host_ctl_we) ctl_q <= host_ctl;
        end
    end

    // Packet word capture during collection.
    always_ff @(posedge clk) begin
        if (host_data_we && state_q == ST_CMD_WR) pkt_w[ofs_q[PIW:1]] <= host_wdata;
    end

    // Selects idle-read pattern versus buffer word for the data port.
    always_ff @(posedge clk) begin
        if (!rst_n)            rd_ffff_q <= 1'b1;
        else if (host_data_re) rd_ffff_q <= ~pio_act;
    end

    assign host_rdata = rd_ffff_q ? 16'hFFFF : buf_rdata;

    for (genvar g = 0; g < PKT_WORDS; g++) begin : g_pkt
        assign pkt_bytes_o[16*g +: 16] = pkt_w[g];
    end

    tf_word_buf #(.WORDS(BUF_WORDS), .AW(BAW)) u_buf (
        .clk(clk), .wr_en(fill_we_i), .wr_addr(fill_addr_i), .wr_data(fill_data_i),
        .rd_en(host_data_re & pio_act), .rd_addr(BAW'(ofs_q >> 1)), .rd_data(buf_rdata)
    );

    tf_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .raise(irq_raise), .clear(irq_clear),
        .mask(ctl_q[1]), .pending_o(pending), .irq_o(irq_o)
    );
endmodule

// File: rtl/tf_ctrl_chk.sv
// Property checker for pkt_taskfile_ctrl, attached by bind below.
module tf_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_we,
    input logic [7:0]  cmd,
    input logic        stat_re,
    input logic        data_re,
    input logic        pio,
    input logic        raise,
    input logic        mask,
    input logic        irq,
    input logic [7:0]  status,
    input logic [7:0]  error,
    input logic [7:0]  ireason,
    input logic        pkt_valid,
    input logic [15:0] rdata
);
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !mask); // R10
    AST_STAT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_re && !status[7] && !raise) |=> !irq); // R11
    AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !raise) |=> !irq); // R11
    AST_PKT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd == 8'hA0) |=> (status == 8'h58 && ireason == 8'h01)); // R2
    AST_DISPATCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (status[7] && !status[3])); // R3
    AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && !pio) |=> rdata == 16'hFFFF); // R6
    AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd == 8'h00) |=> (status == 8'h51 && error == 8'h04)); // R8
endmodule

bind pkt_taskfile_ctrl tf_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(host_cmd_we), .cmd(host_cmd),
    .stat_re(host_stat_re), .data_re(host_data_re), .pio(pio_act),
    .raise(irq_raise), .mask(ctl_q[1]), .irq(irq_o), .status(status_o),
    .error(error_o), .ireason(ireason_o), .pkt_valid(pkt_valid_o), .rdata(host_rdata)
);

// File: tb/tb_pkt_taskfile_ctrl.sv
module tb_pkt_taskfile_ctrl;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_we = 0, ctl_we = 0, feat_we = 0, data_we = 0, data_re = 0, stat_re = 0;
    logic [7:0] cmd = 0, ctl = 0, feat = 0;
    logic [15:0] wdata = 0, rdata;
    logic [7:0] status, error, irsn, sect, blo, bhi;
    logic rs, irq, pv, done = 0, perr = 0, fill_we = 0, dma_done = 0;
    logic [95:0] pbytes;
    logic [3:0] code = 0;
    logic [11:0] len = 0;
    logic [10:0] faddr = 0;
    logic [15:0] fdata = 0;
    int n_run = 0, n_fail = 0;
    bit finished = 0, armed = 0;

    always #2 clk = ~clk;

    pkt_taskfile_ctrl dut (
        .clk(clk), .rst_n(rst_n), .host_cmd_we(cmd_we), .host_cmd(cmd),
        .host_ctl_we(ctl_we), .host_ctl(ctl), .host_feat_we(feat_we), .host_feat(feat),
        .host_data_we(data_we), .host_wdata(wdata), .host_data_re(data_re),
        .host_rdata(rdata), .host_stat_re(stat_re), .status_o(status), .error_o(error),
        .ireason_o(irsn), .sect_o(sect), .bcnt_lo_o(blo), .bcnt_hi_o(bhi),
        .rst_seen_o(rs), .irq_o(irq), .pkt_valid_o(pv), .pkt_bytes_o(pbytes),
        .pkt_done_i(done), .pkt_err_i(perr), .pkt_code_i(code), .pkt_len_i(len),
        .fill_we_i(fill_we), .fill_addr_i(faddr), .fill_data_i(fdata), .dma_done_i(dma_done)
    );

    task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced at each rising edge.
    int m_st, m_ofs, m_len;
    logic [7:0] m_status, m_err, m_ir, m_sect, m_blo, m_bhi, m_ctl, m_feat;
    logic [15:0] m_rd;
    bit m_rs, m_pend, m_pv, m_raise, m_clr;
    logic [15:0] m_buf [int];
    logic [7:0] m_pkt [12];

    always @(posedge clk) begin
        armed <= 1;
        m_pv = 0; m_raise = 0;
        if (!rst_n) begin
            m_st = 0; m_status = 8'h00; m_err = 8'h01; m_ir = 8'h01; m_sect = 8'h81;
            m_blo = 8'h14; m_bhi = 8'hEB; m_ctl = 0; m_feat = 0; m_rs = 1; m_pend = 0;
            m_rd = 16'hFFFF; m_ofs = 0; m_len = 0;
        end else begin
            if (fill_we) m_buf[int'(faddr)] = fdata;
            if (data_re) m_rd = (m_st == 3) ? m_buf[m_ofs / 2] : 16'hFFFF;
            m_clr = cmd_we || (stat_re && !m_status[7]);
            if (cmd_we) begin
                if (cmd == 8'h00) begin
                    m_st = 0; m_status = 8'h51; m_err = 8'h04; m_ofs = 0; m_raise = 1;
                end else if (cmd == 8'h08) begin
                    m_st = 0; m_status = 0; m_err = 1; m_ir = 1; m_sect = 8'h81;
                    m_blo = 8'h14; m_bhi = 8'hEB; m_feat = 0; m_rs = 1; m_ofs = 0;
                end else if (cmd == 8'hA0) begin
                    m_st = 1; m_status = 8'h58; m_err = {6'b0, m_feat[1:0]}; m_ir = 1;
                    m_ofs = 0; m_len = 12;
                end else if (cmd == 8'hEF) begin
                    m_status = 8'h50; m_err = 0; m_blo = 0; m_bhi = 0; m_raise = 1;
                end
            end else if (data_we && m_st == 1) begin
                m_pkt[m_ofs] = wdata[7:0]; m_pkt[m_ofs + 1] = wdata[15:8];
                m_ofs += 2;
                if (m_ofs >= 12) begin
                    m_st = 2; m_status = (m_status & 8'hF7) | 8'h80; m_ofs = 0; m_pv = 1; m_rs = 0;
                end
            end else if (data_re && m_st == 3) begin
                m_ofs += 2;
                if (m_ofs >= m_len) begin
                    m_st = 0; m_status = m_status & 8'hF7; m_ir = 3; m_raise = 1; m_ofs = 0;
                end
            end else if (m_st == 2 && done) begin
                if (perr) begin
                    m_st = 0; m_status = 8'h51; m_err = {code, 4'b0}; m_ir = 3; m_raise = 1;
                end else if (len == 0) begin
                    m_st = 0; m_status = 8'h50; m_err = 0; m_ir = 3; m_raise = 1;
                end else begin
                    m_err = 0; m_ir = 2; m_ofs = 0; m_len = int'(len);
                    if (m_feat[0]) begin m_st = 4; m_status = 8'hD0; end
                    else begin
                        m_st = 3; m_status = 8'h58; m_blo = len[7:0]; m_bhi = {4'b0, len[11:8]};
                        m_raise = 1;
                    end
                end
            end else if (m_st == 4 && dma_done) begin
                m_st = 0; m_status = 8'h50; m_ir = 3; m_raise = 1;
            end
            if (m_raise) m_pend = 1; else if (m_clr) m_pend = 0;
            if (ctl_we) m_ctl = ctl;
            if (feat_we) m_feat = feat;
        end
    end

    // Model comparison on every clock, away from the active edge.
    always @(negedge clk) begin
        if (armed && !finished) begin
            chk("model status", status, m_status);
            chk("model error", error, m_err);
            chk("model ireason", irsn, m_ir);
            chk("model bytecount", {sect, blo, bhi}, {m_sect, m_blo, m_bhi});
            chk("model rst_seen", rs, m_rs);
            chk("model irq R10", irq, m_pend && !m_ctl[1]);
            chk("model rdata", rdata, m_rd);
            chk("model pkt strobe", pv, m_pv);
            if (m_pv) for (int i = 0; i < 12; i++) chk("model pkt byte", pbytes[8*i +: 8], m_pkt[i]);
        end
    end

    task automatic op_cmd(logic [7:0] v);  cmd = v; cmd_we = 1; @(negedge clk); cmd_we = 0; endtask
    task automatic op_ctl(logic [7:0] v);  ctl = v; ctl_we = 1; @(negedge clk); ctl_we = 0; endtask
    task automatic op_feat(logic [7:0] v); feat = v; feat_we = 1; @(negedge clk); feat_we = 0; endtask
    task automatic op_wr(logic [15:0] v);  wdata = v; data_we = 1; @(negedge clk); data_we = 0; endtask
    task automatic op_rd();   data_re = 1; @(negedge clk); data_re = 0; endtask
    task automatic op_stat(); stat_re = 1; @(negedge clk); stat_re = 0; endtask
    task automatic op_fill(int a, logic [15:0] v);
        faddr = 11'(a); fdata = v; fill_we = 1; @(negedge clk); fill_we = 0;
    endtask
    task automatic op_done(logic e, logic [3:0] c, logic [11:0] l);
        perr = e; code = c; len = l; done = 1; @(negedge clk); done = 0; perr = 0;
    endtask
    task automatic send_packet();
        op_cmd(8'hA0);
        for (int k = 0; k < 6; k++) op_wr({8'(2*k + 2), 8'(2*k + 1)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 status", status, 8'h00); chk("R1 error", error, 8'h01);
        chk("R1 ireason", irsn, 8'h01);
        chk("R1 sect/bcnt", {sect, blo, bhi}, 24'h8114EB);
        chk("R1 rst_seen", rs, 1'b1); chk("R1 irq", irq, 1'b0); chk("R1 rdata", rdata, 16'hFFFF);
        rst_n = 1; @(negedge clk);
        op_ctl(8'h00); op_feat(8'h02);
        op_cmd(8'hA0);
        chk("R2 status", status, 8'h58); chk("R2 error", error, 8'h02); chk("R2 ireason", irsn, 8'h01);
        for (int k = 0; k < 6; k++) op_wr({8'(2*k + 2), 8'(2*k + 1)});
        chk("R3 status", status, 8'hD0); chk("R3 strobe", pv, 1'b1);
        chk("R3 bytes", pbytes, 96'h0c0b0a09_08070605_04030201); chk("R3 rst_seen", rs, 1'b0);
        op_wr(16'hDEAD);
        chk("R3 ignored write", {status, 7'b0, pv}, {8'hD0, 8'h00});
        for (int k = 0; k < 4; k++) op_fill(k, 16'hA000 + 16'(k));
        op_done(0, 0, 12'd7);
        chk("R5 status", status, 8'h58); chk("R5 ireason", irsn, 8'h02);
        chk("R5 bcnt", {blo, bhi}, 16'h0700); chk("R5 irq", irq, 1'b1); chk("R5 error", error, 8'h00);
        op_stat();
        chk("R11 status ack", irq, 1'b0);
        for (int k = 0; k < 4; k++) begin
            op_rd();
            chk("R6 word", rdata, 16'hA000 + 16'(k));
        end
        chk("R6 status", status, 8'h50); chk("R6 ireason", irsn, 8'h03); chk("R6 irq", irq, 1'b1);
        op_rd();
        chk("R6 idle read", rdata, 16'hFFFF);
        op_ctl(8'h02); chk("R10 masked", irq, 1'b0);
        op_ctl(8'h00); chk("R10 unmasked", irq, 1'b1);
        op_cmd(8'h55);
        chk("R11 cmd clears", irq, 1'b0); chk("R11 status kept", status, 8'h50);
        op_cmd(8'h00);
        chk("R8 status", status, 8'h51); chk("R8 error", error, 8'h04); chk("R8 irq", irq, 1'b1);
        op_feat(8'h01); send_packet();
        chk("R2 dma flag copy", error, 8'h01);
        op_done(0, 0, 12'd2352);
        chk("R7 status", status, 8'hD0); chk("R7 ireason", irsn, 8'h02);
        chk("R7 irq", irq, 1'b0); chk("R7 bcnt kept", {blo, bhi}, 16'h0700);
        op_stat(); chk("R11 busy no ack", status, 8'hD0);
        dma_done = 1; @(negedge clk); dma_done = 0;
        chk("R7 done status", status, 8'h50); chk("R7 done ireason", irsn, 8'h03); chk("R7 done irq", irq, 1'b1);
        op_feat(8'h00); send_packet();
        op_done(1, 4'h5, 12'd0);
        chk("R4 err status", status, 8'h51); chk("R4 err code", error, 8'h50);
        chk("R4 err ireason", irsn, 8'h03); chk("R4 err irq", irq, 1'b1);
        op_stat(); chk("R11 ack after error", irq, 1'b0);
        send_packet(); op_done(0, 0, 12'd0);
        chk("R4 ok status", status, 8'h50); chk("R4 ok error", error, 8'h00);
        chk("R4 ok ireason", irsn, 8'h03); chk("R4 ok irq", irq, 1'b1);
        op_cmd(8'hEF);
        chk("R9 status", status, 8'h50); chk("R9 error", error, 8'h00);
        chk("R9 bcnt", {blo, bhi}, 16'h0000); chk("R9 irq", irq, 1'b1);
        op_ctl(8'h02);
        op_cmd(8'h08);
        chk("R12 regs", {status, error, irsn, sect, blo, bhi}, 48'h0001_0181_14EB);
        chk("R12 rst_seen", rs, 1'b1);
        op_ctl(8'h00); chk("R12 pending cleared", irq, 1'b0);
        repeat (2) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule